// File: doc/BRIEF.md
# Latched Event Status Register

This block holds a bank of sticky event flags that a processor reads through a simple synchronous register port. Each flag watches one live status input. When that input goes from 0 to 1 and its source is enabled, the flag sets and stays set until software or the data path clears it. The flags leave the bank through the read port and also through a single interrupt line, which is gated by a per-flag interrupt enable register.

Software selects one of two ways to clear flags with a mode input. In clear-on-read mode, reading the flag register returns the current flags and clears exactly those flags that the read returned as 1. An event that arrives in the same cycle as the read is therefore kept. In write-one-to-clear mode, reads have no side effect, and software clears flags by writing ones to them. A synchronous data-path clear input wipes every flag at once, for example after a mode change.

Top module: `evt_latch_bank`

## Requirements
- R1: After reset, the flag register and the interrupt enable register read 0 and `irq` is 0. The previous-value tracker also resets to 0, so a source that is already high at the first cycle after reset counts as a rising event.
- R2: A 0-to-1 transition on `status_in[i]`, with `src_en[i]` high, sets flag i at that clock edge. The flag then holds while no clear applies.
- R3: When `clr_on_rd`=1, a cycle with `bus_rd`=1 and `bus_sel`=0 returns the flags on `bus_rdata` in the same cycle and clears, at that edge, every flag that it returned as 1.
- R4: In clear-on-read mode, a rising event on a flag that read as 0 during the read cycle is still latched after the read.
- R5: When `clr_on_rd`=0, a cycle with `bus_wr`=1 and `bus_sel`=0 clears each flag whose `bus_wdata` bit is 1 and leaves flags under 0 bits unchanged.
- R6: In write-one-to-clear mode, a rising event in the same cycle as a write that clears that flag wins, and the flag stays set.
- R7: A write to the flag register (`bus_sel`=0) in clear-on-read mode changes no flag. A read in write-one-to-clear mode, or any read with `bus_sel`=1, clears no flag.
- R8: `dp_clr`=1 clears all flags at the next edge, even when an event arrives in that cycle.
- R9: A rising edge on a source whose `src_en` bit is 0 sets no flag.
- R10: `bus_sel`=1 selects the interrupt enable register, which is written by `bus_wr` and read by `bus_rdata`. `irq` is 1 exactly when some flag and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_on_rd | input | 1 | Clear method: 1 selects clear-on-read, 0 selects write-one-to-clear |
| dp_clr | input | 1 | Synchronous data-path clear of all flags |
| src_en | input | WIDTH | Per-source mode enable; a disabled source cannot set its flag |
| status_in | input | WIDTH | Live status inputs |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_sel | input | 1 | 0 selects the flag register, 1 selects the interrupt enable register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data of the selected register, valid in the strobe cycle |
| irq | output | 1 | OR of the enabled flags |

## Verification
The assertions assume that `rst_n` is synchronous and that the inputs settle well away from the rising clock edge. They also assume that `bus_rd` and `bus_wr` are never both high in one cycle. The stimulus changes every input on the falling edge and never raises both strobes together. Status inputs are toggled low and then high on purpose, so that each rising edge can be placed in exactly the cycle under test, including the read, write and data-path clear cycles.

// File: rtl/evt_latch_pkg.sv
// Package: shared encodings for the latched event status bank.
// Assumes: nothing beyond IEEE 1800-2017.
package evt_latch_pkg;

    typedef enum logic {
        CLR_W1C  = 1'b0,
        CLR_READ = 1'b1
    } clr_mode_e;

    typedef enum logic {
        SEL_FLAGS  = 1'b0,
        SEL_IRQ_EN = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/evt_rise_detect.sv
// Module: evt_rise_detect
// Registers the previous value of each live input and flags 0-to-1 steps.
// Assumes: inputs are synchronous to clk; the previous value resets to 0.
module evt_rise_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig_in,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev_q;

    // Purpose: remember last cycle's input value.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig_in;
    end

    // Purpose: a rise is high now, low last cycle.
    always_comb rise = sig_in & ~prev_q;

endmodule

// File: rtl/evt_latch_bit.sv
// Module: evt_latch_bit
// One sticky flag: set by an event, cleared by a request or data-path clear.
// Assumes: a data-path clear overrides everything; an event overrides a request.
module evt_latch_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr_req,
    input  logic dp_clr,
    output logic q
);

    logic q_next;

    // Purpose: choose the next flag value by priority.
    always_comb begin
        if (dp_clr)       q_next = 1'b0;
        else if (evt)     q_next = 1'b1;
        else if (clr_req) q_next = 1'b0;
        else              q_next = q;
    end

    // Purpose: hold the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_next;
    end

    p_dp_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dp_clr |=> !q);
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !dp_clr) |=> q);
    p_request_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !evt && !dp_clr) |=> !q);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !clr_req && !dp_clr) |=> $stable(q));

endmodule

// File: rtl/evt_irq_ctrl.sv
// Module: evt_irq_ctrl
// Holds the per-flag interrupt enable register and forms the interrupt line.
// Assumes: the enable register is written only when the bus selects it.
module evt_irq_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic [WIDTH-1:0] en_wdata,
    input  logic [WIDTH-1:0] flags,
    output logic [WIDTH-1:0] irq_en,
    output logic             irq
);

    // Purpose: store the interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_en <= '0;
        else if (en_wr) irq_en <= en_wdata;
    end

    // Purpose: OR of enabled flags.
    always_comb irq = |(flags & irq_en);

    p_en_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> (irq_en == $past(en_wdata)));
    p_en_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr |=> $stable(irq_en));

endmodule

// File: rtl/evt_latch_bank.sv
// Module: evt_latch_bank (top)
// Bank of sticky event flags behind a single-register read/write port, with
// clear-on-read or write-one-to-clear selectable, data-path clear and interrupt.
// Assumes: bus_rd and bus_wr are never high together; one cycle per access.
module evt_latch_bank
    import evt_latch_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_on_rd,
    input  logic             dp_clr,
    input  logic [WIDTH-1:0] src_en,
    input  logic [WIDTH-1:0] status_in,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic             bus_sel,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    output logic             irq
);

    clr_mode_e        mode;
    reg_sel_e         sel;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] evt;
    logic [WIDTH-1:0] flags;
    logic [WIDTH-1:0] clr_req;
    logic [WIDTH-1:0] irq_en;
    logic             read_clr_hit;
    logic             write_clr_hit;
    logic             en_wr;

    // Purpose: decode mode and register select into typed form.
    always_comb begin
        mode = clr_mode_e'(clr_on_rd);
        sel  = reg_sel_e'(bus_sel);
    end

    evt_rise_detect #(.WIDTH(WIDTH)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (status_in),
        .rise   (rise)
    );

    // Purpose: qualify rises by source enable and form per-bit clear requests.
    always_comb begin
        evt           = rise & src_en;
        read_clr_hit  = bus_rd && (sel == SEL_FLAGS) && (mode == CLR_READ);
        write_clr_hit = bus_wr && (sel == SEL_FLAGS) && (mode == CLR_W1C);
        en_wr         = bus_wr && (sel == SEL_IRQ_EN);
        clr_req       = ({WIDTH{read_clr_hit}} & flags)
                      | ({WIDTH{write_clr_hit}} & bus_wdata);
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        evt_latch_bit u_bit (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt[i]),
            .clr_req (clr_req[i]),
            .dp_clr  (dp_clr),
            .q       (flags[i])
        );
    end

    evt_irq_ctrl #(.WIDTH(WIDTH)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_wr    (en_wr),
        .en_wdata (bus_wdata),
        .flags    (flags),
        .irq_en   (irq_en),
        .irq      (irq)
    );

    // Purpose: return the selected register.
    always_comb bus_rdata = (sel == SEL_IRQ_EN) ? irq_en : flags;

    p_no_dual_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_disabled_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & ~$past(flags) & ~$past(src_en)) == '0));
    p_read_w1c_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !clr_on_rd && !dp_clr) |=> ((flags & $past(flags)) == $past(flags)));
    p_cor_write_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_sel && clr_on_rd && !dp_clr) |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: tb/evt_latch_bank_bench.sv
module evt_latch_bank_bench;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         clr_on_rd;
    logic         dp_clr;
    logic [W-1:0] src_en;
    logic [W-1:0] status_in;
    logic         bus_rd;
    logic         bus_wr;
    logic         bus_sel;
    logic [W-1:0] bus_wdata;
    logic [W-1:0] bus_rdata;
    logic         irq;

    int n_run  = 0;
    int n_fail = 0;

    // behavioural reference state
    logic [W-1:0] m_flags, m_en, m_prev;

    always #5 clk = ~clk;

    evt_latch_bank #(.WIDTH(W)) u_evt_latch_bank (
        .clk(clk), .rst_n(rst_n), .clr_on_rd(clr_on_rd), .dp_clr(dp_clr),
        .src_en(src_en), .status_in(status_in), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then step the model at the rising edge.
    task automatic cyc(string tag, logic rd, logic wr, logic sel,
                       logic [W-1:0] wd, logic [W-1:0] st);
        logic [W-1:0] r;
        logic [W-1:0] nf;
        bus_rd = rd; bus_wr = wr; bus_sel = sel; bus_wdata = wd; status_in = st;
        #1;
        check({tag, " rdata"}, bus_rdata, sel ? m_en : m_flags);
        check({tag, " irq"}, {7'b0, irq}, {7'b0, |(m_flags & m_en)});
        @(posedge clk);
        if (!rst_n) begin
            m_flags = '0; m_en = '0; m_prev = '0;
        end else begin
            r  = st & ~m_prev & src_en;
            nf = m_flags;
            if (rd && !sel && clr_on_rd)  nf = nf & ~m_flags;
            if (wr && !sel && !clr_on_rd) nf = nf & ~wd;
            nf = nf | r;
            if (dp_clr) nf = '0;
            if (wr && sel) m_en = wd;
            m_flags = nf;
            m_prev  = st;
        end
        @(negedge clk);
    endtask

    // Direct look at the flag register through a side-effect-free access.
    task automatic peek(string tag, logic [W-1:0] exp);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_sel = 1'b0;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] st;
        rst_n = 1'b0; clr_on_rd = 1'b1; dp_clr = 1'b0; src_en = '1;
        st = '0; m_flags = '0; m_en = '0; m_prev = '0;
        @(negedge clk);
        cyc("R1 reset", 0, 0, 0, '0, st);
        cyc("R1 reset", 0, 0, 0, '0, st);
        rst_n = 1'b1;
        cyc("R1 idle", 0, 0, 0, '0, st);
        peek("R1 flags zero", 8'h00);
        cyc("R1 en zero", 0, 0, 1, '0, st);

        // clear-on-read
        st = 8'h05; cyc("R2 rise", 0, 0, 0, '0, st);
        cyc("R2 hold", 0, 0, 0, '0, st);
        peek("R2 latched", 8'h05);
        st = 8'h00; cyc("R2 fall keeps", 0, 0, 0, '0, st);
        peek("R2 still set", 8'h05);
        cyc("R3 read", 1, 0, 0, '0, st);
        peek("R3 cleared", 8'h00);
        st = 8'h01; cyc("R2 rise b0", 0, 0, 0, '0, st);
        st = 8'h03; cyc("R4 read with event", 1, 0, 0, '0, st);
        peek("R4 kept b1", 8'h02);
        cyc("R7 cor write", 0, 1, 0, 8'hFF, st);
        peek("R7 cor write ignored", 8'h02);
        cyc("R7 sel1 read", 1, 0, 1, '0, st);
        peek("R7 sel1 read no clear", 8'h02);
        cyc("R3 read2", 1, 0, 0, '0, st);
        peek("R3 cleared2", 8'h00);

        // write-one-to-clear
        clr_on_rd = 1'b0;
        st = 8'h00; cyc("idle", 0, 0, 0, '0, st);
        st = 8'hF4; cyc("R2 rise F4", 0, 0, 0, '0, st);
        cyc("R7 w1c read", 1, 0, 0, '0, st);
        peek("R7 read no clear", 8'hF4);
        cyc("R5 write 30", 0, 1, 0, 8'h30, st);
        peek("R5 partial clear", 8'hC4);
        st = 8'h00; cyc("fall", 0, 0, 0, '0, st);
        st = 8'h04; cyc("R6 event vs clear", 0, 1, 0, 8'h04, st);
        peek("R6 event wins", 8'hC4);
        cyc("R5 clear all", 0, 1, 0, 8'hFF, st);
        peek("R5 empty", 8'h00);

        // source enable
        src_en = 8'h0F;
        st = 8'h00; cyc("fall", 0, 0, 0, '0, st);
        st = 8'h81; cyc("R9 gated rise", 0, 0, 0, '0, st);
        peek("R9 only b0", 8'h01);

        // interrupt enable
        src_en = 8'hFF;
        cyc("R10 en write", 0, 1, 1, 8'h02, st);
        cyc("R10 en read", 1, 0, 1, '0, st);
        check("R10 irq low", {7'b0, irq}, 8'h00);
        st = 8'h83; cyc("R10 rise b1", 0, 0, 0, '0, st);
        check("R10 irq high", {7'b0, irq}, 8'h01);

        // data-path clear
        st = 8'h00; cyc("fall", 0, 0, 0, '0, st);
        dp_clr = 1'b1; st = 8'h10; cyc("R8 dp clear", 0, 0, 0, '0, st);
        dp_clr = 1'b0;
        peek("R8 all clear", 8'h00);
        check("R8 irq low", {7'b0, irq}, 8'h00);
        cyc("idle", 0, 0, 0, '0, st);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule